// File: doc/BRIEF.md
# Macro-Op Expansion and Compare-Branch Fusion Stage

This block is the last step of instruction decode. It takes a group of up to four pre-classified instruction descriptors per cycle. Each descriptor carries an operation class, a wide-operand flag, a macro-op count and a tag. The block turns them into fixed-format macro-ops on a four-lane output toward the dispatch queue.

The datapath is 128 bits wide. A 256-bit operation is therefore emitted as two macro-ops, the low half first and then the high half. An instruction that asks for two macro-ops is also emitted as a pair. An instruction that needs more than two is not expanded here: it is sent to a microcode sequencer through a request port, and the fast path waits until the sequencer reports completion. A compare or test that sits directly before a conditional jump in the same group is merged into a single macro-op.

Program order is always kept. If the macro-ops of a group do not fit in the four lanes, the instructions that do not fit stay in the block and are emitted in the next cycle. The input is not accepted again until the whole group has been emitted.

Top module: `mop_decoder`

## Requirements
- R1: After reset no output lane is valid, no microcode request is raised, and `in_ready` is high.
- R2: Slot k of `in_desc` occupies bits [14k+13:14k] and is packed as {tag[13:6], count[5:4], wide[3], class[2:1], valid[0]}. Lane k of `out_op` occupies bits [12k+11:12k] and is packed as {tag[11:4], class[3:2], fused[1], part[0]}. A single-op instruction (count 1, not wide) gives one macro-op with its own tag and class, part 0 and fused 0. Macro-ops fill the lanes from lane 0 with no gaps, in slot order.
- R3: A wide instruction (wide = 1, count below 3) gives two macro-ops in adjacent lanes with the same tag: part 0 for the low half, then part 1 for the high half.
- R4: An instruction with count 2 that is not wide also gives two adjacent macro-ops, with part 0 and then part 1.
- R5: A compare/test (class 1) that is single-op and is followed in the next slot by a single-op conditional jump (class 2) gives one macro-op. That macro-op has class 2, fused 1, part 0 and the compare's tag. The jump gives no macro-op of its own.
- R6: Fusion happens only within one input group. A compare in slot 3 and a jump in slot 0 of the next group stay separate and unfused. A wide compare is also not fused.
- R7: An instruction whose macro-ops do not all fit in the lanes left in this cycle is emitted whole in the next cycle, never split across cycles. `in_ready` stays low while any instruction of the group is still held.
- R8: An instruction with count 3 raises `mc_req_valid` with its tag only after all earlier instructions of the group have left. It never appears on an output lane. While `mc_req_valid` is high, no output lane is valid, and the request and its tag stay unchanged until `mc_req_ready`.
- R9: After a request is accepted, no output lane is valid and no new request is raised until `mc_done` is pulsed. Emission of the rest of the group then resumes.
- R10: While `out_ready` is low, the output lanes hold their values and nothing is consumed.
- R11: `in_ready` is high in the cycle in which the last held instructions of a group leave, so that back-to-back groups run without a bubble cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor group is valid |
| in_ready | output | 1 | Stage can take a new group |
| in_desc | input | 56 | Four descriptor slots, packed as in R2 |
| out_vld | output | 4 | Per-lane macro-op valid |
| out_op | output | 48 | Four macro-op lanes, packed as in R2 |
| out_ready | input | 1 | Dispatch queue takes all valid lanes |
| mc_req_valid | output | 1 | Microcode sequence request |
| mc_req_tag | output | 8 | Tag of the instruction sent to microcode |
| mc_req_ready | input | 1 | Sequencer accepts the request |
| mc_done | input | 1 | Sequencer has finished the current sequence |

## Verification
The assertions check the following on every cycle:
- lane packing, with no gaps;
- pairing of high halves with their low halves in the same cycle;
- the class and part of fused macro-ops;
- holding of lanes and of requests under back-pressure;
- silence of the fast path while a microcode sequence runs.

Other properties depend on the particular input groups and can only be shown by the bench's scenarios. These are which slots fuse and which do not, the exact spill point when a group overflows the four lanes, the resumption order after `mc_done`, and the absence of a bubble between back-to-back groups.

// File: rtl/mop_decoder.sv
module mop_decoder #(
  parameter int NS = 4,
  parameter int TW = 8,
  localparam int SW = TW + 6,
  localparam int OW = TW + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NS*SW-1:0] in_desc,
  output logic [NS-1:0]    out_vld,
  output logic [NS*OW-1:0] out_op,
  input  logic             out_ready,
  output logic             mc_req_valid,
  output logic [TW-1:0]    mc_req_tag,
  input  logic             mc_req_ready,
  input  logic             mc_done
);
  localparam logic [1:0] CLS_CMP = 2'd1;
  localparam logic [1:0] CLS_JCC = 2'd2;

  logic [SW-1:0] grp [NS];
  logic [NS-1:0] pend, take, ucode, two, single, fuse_ok;
  logic          busy, stop, skip, fire_fast, fire_mc, adv;
  int            used;

  for (genvar i = 0; i < NS; i++) begin : g_slot
    assign ucode[i]  = grp[i][5:4] == 2'd3;
    assign two[i]    = !ucode[i] && (grp[i][3] || grp[i][5:4] == 2'd2);
    assign single[i] = !ucode[i] && !two[i];
    if (i < NS - 1) begin : g_fuse
      assign fuse_ok[i] = pend[i] && pend[i+1] && grp[i+1][0] && single[i] && single[i+1]
                          && grp[i][2:1] == CLS_CMP && grp[i+1][2:1] == CLS_JCC;
    end else begin : g_last
      assign fuse_ok[i] = 1'b0;
    end
  end

  always_comb begin
    out_vld      = '0;
    out_op       = '0;
    take         = '0;
    mc_req_valid = 1'b0;
    mc_req_tag   = '0;
    used         = 0;
    stop         = busy;
    skip         = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (skip) begin
        take[i] = 1'b1;
        skip    = 1'b0;
      end else if (!stop && pend[i]) begin
        if (ucode[i]) begin
          if (used == 0) begin
            mc_req_valid = 1'b1;
            mc_req_tag   = grp[i][SW-1:6];
            take[i]      = 1'b1;
          end
          stop = 1'b1;
        end else if (fuse_ok[i]) begin
          if (used < NS) begin
            out_vld[used]          = 1'b1;
            out_op[used*OW +: OW]  = {grp[i][SW-1:6], CLS_JCC, 1'b1, 1'b0};
            take[i]                = 1'b1;
            skip                   = 1'b1;
            used                   = used + 1;
          end else begin
            stop = 1'b1;
          end
        end else if (two[i]) begin
          if (used + 2 <= NS) begin
            out_vld[used]              = 1'b1;
            out_op[used*OW +: OW]      = {grp[i][SW-1:6], grp[i][2:1], 1'b0, 1'b0};
            out_vld[used+1]            = 1'b1;
            out_op[(used+1)*OW +: OW]  = {grp[i][SW-1:6], grp[i][2:1], 1'b0, 1'b1};
            take[i]                    = 1'b1;
            used                       = used + 2;
          end else begin
            stop = 1'b1;
          end
        end else begin
          if (used < NS) begin
            out_vld[used]         = 1'b1;
            out_op[used*OW +: OW] = {grp[i][SW-1:6], grp[i][2:1], 1'b0, 1'b0};
            take[i]               = 1'b1;
            used                  = used + 1;
          end else begin
            stop = 1'b1;
          end
        end
      end
    end
  end

  assign fire_fast = out_ready && |out_vld;
  assign fire_mc   = mc_req_valid && mc_req_ready;
  assign adv       = fire_fast || fire_mc;
  assign in_ready  = !(|pend) || (adv && (pend & ~take) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      busy <= 1'b0;
      for (int i = 0; i < NS; i++) grp[i] <= '0;
    end else begin
      if (fire_mc) busy <= 1'b1;
      else if (mc_done) busy <= 1'b0;
      if (in_valid && in_ready) begin
        for (int i = 0; i < NS; i++) begin
          grp[i]  <= in_desc[i*SW +: SW];
          pend[i] <= in_desc[i*SW];
        end
      end else if (adv) begin
        pend <= pend & ~take;
      end
    end
  end
endmodule

// File: rtl/mop_decoder_chk.sv
module mop_decoder_chk #(
  parameter int NS = 4,
  parameter int TW = 8,
  localparam int OW = TW + 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NS-1:0]    out_vld,
  input logic [NS*OW-1:0] out_op,
  input logic             out_ready,
  input logic             mc_req_valid,
  input logic [TW-1:0]    mc_req_tag,
  input logic             mc_req_ready,
  input logic             mc_done
);
  logic busy_q;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (mc_req_valid && mc_req_ready) busy_q <= 1'b1;
    else if (mc_done) busy_q <= 1'b0;
  end

  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld & (out_vld + 1'b1)) == '0)); // R2

  AST_LANE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld[0] |-> !out_op[0]); // R7

  for (genvar i = 1; i < NS; i++) begin : g_pair
    AST_HIGH_HALF_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[i] && out_op[i*OW]) |->
        (out_vld[i-1] && !out_op[(i-1)*OW] &&
         out_op[i*OW+4 +: TW] == out_op[(i-1)*OW+4 +: TW])); // R3
  end

  for (genvar i = 0; i < NS; i++) begin : g_fused
    AST_FUSED_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[i] && out_op[i*OW+1]) |-> (out_op[i*OW+2 +: 2] == 2'd2 && !out_op[i*OW])); // R5
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_vld && !out_ready) |=> ($stable(out_vld) && $stable(out_op))); // R10

  AST_MC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_req_valid |-> out_vld == '0); // R8

  AST_MC_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_req_valid && !mc_req_ready) |=> (mc_req_valid && $stable(mc_req_tag))); // R8

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (out_vld == '0 && !mc_req_valid)); // R9
endmodule

bind mop_decoder mop_decoder_chk #(.NS(NS), .TW(TW)) chk (.*);

// File: tb/mop_decoder_test.sv
module mop_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [55:0] in_desc = '0;
  logic [3:0]  out_vld;
  logic [47:0] out_op;
  logic        out_ready = 1'b1;
  logic        mc_req_valid;
  logic [7:0]  mc_req_tag;
  logic        mc_req_ready = 1'b1;
  logic        mc_done = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  mop_decoder uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [13:0] sl(input logic [7:0] tag, input logic [1:0] cnt,
                                     input logic wide, input logic [1:0] cls);
    return {tag, cnt, wide, cls, 1'b1};
  endfunction

  function automatic logic [11:0] mk(input logic [7:0] tag, input logic [1:0] cls,
                                     input logic fused, input logic part);
    return {tag, cls, fused, part};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [3:0] ev,
                           input logic [11:0] l0, input logic [11:0] l1,
                           input logic [11:0] l2, input logic [11:0] l3);
    logic [11:0] e [4];
    e[0] = l0; e[1] = l1; e[2] = l2; e[3] = l3;
    check({req, " lanes valid"}, {28'd0, out_vld}, {28'd0, ev});
    for (int k = 0; k < 4; k++)
      if (ev[k]) check({req, " lane op"}, {20'd0, out_op[k*12 +: 12]}, {20'd0, e[k]});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [13:0] s3, input logic [13:0] s2,
                      input logic [13:0] s1, input logic [13:0] s0);
    in_valid = 1'b1;
    in_desc  = {s3, s2, s1, s0};
    tick();
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 out_vld", {28'd0, out_vld}, 32'd0);
    check("R1 mc_req_valid", {31'd0, mc_req_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_single();
    send(sl(8'h04,1,0,3), sl(8'h03,1,0,0), sl(8'h02,1,0,2), sl(8'h01,1,0,0));
    check_out("R2 four single ops", 4'b1111, mk(8'h01,0,0,0), mk(8'h02,2,0,0),
              mk(8'h03,0,0,0), mk(8'h04,3,0,0));
    tick();
    check_out("R2 group drained", 4'b0000, 0, 0, 0, 0);
  endtask

  task automatic t_wide();
    send(sl(8'h13,1,0,0), sl(8'h12,1,1,0), sl(8'h11,1,0,0), sl(8'h10,1,1,0));
    check_out("R3 wide first cycle", 4'b0111, mk(8'h10,0,0,0), mk(8'h10,0,0,1),
              mk(8'h11,0,0,0), 0);
    check("R7 in_ready low while held", {31'd0, in_ready}, 32'd0);
    tick();
    check_out("R7 spilled wide next cycle", 4'b0111, mk(8'h12,0,0,0), mk(8'h12,0,0,1),
              mk(8'h13,0,0,0), 0);
    tick();
  endtask

  task automatic t_two();
    send(14'd0, sl(8'h72,2,0,3), sl(8'h71,2,0,3), sl(8'h70,2,0,3));
    check_out("R4 double ops", 4'b1111, mk(8'h70,3,0,0), mk(8'h70,3,0,1),
              mk(8'h71,3,0,0), mk(8'h71,3,0,1));
    tick();
    check_out("R7 third double op", 4'b0011, mk(8'h72,3,0,0), mk(8'h72,3,0,1), 0, 0);
    tick();
  endtask

  task automatic t_fuse();
    send(sl(8'h23,1,0,2), sl(8'h22,1,0,0), sl(8'h21,1,0,2), sl(8'h20,1,0,1));
    check_out("R5 compare-jump fused", 4'b0111, mk(8'h20,2,1,0), mk(8'h22,0,0,0),
              mk(8'h23,2,0,0), 0);
    tick();
    send(14'd0, 14'd0, sl(8'h46,1,0,2), sl(8'h45,1,1,1));
    check_out("R6 wide compare not fused", 4'b0111, mk(8'h45,1,0,0), mk(8'h45,1,0,1),
              mk(8'h46,2,0,0), 0);
    tick();
  endtask

  task automatic t_cross();
    send(sl(8'h33,1,0,1), sl(8'h32,1,0,0), sl(8'h31,1,0,0), sl(8'h30,1,0,0));
    check_out("R6 compare in last slot", 4'b1111, mk(8'h30,0,0,0), mk(8'h31,0,0,0),
              mk(8'h32,0,0,0), mk(8'h33,1,0,0));
    check("R11 in_ready on finishing cycle", {31'd0, in_ready}, 32'd1);
    send(14'd0, 14'd0, sl(8'h41,1,0,0), sl(8'h40,1,0,2));
    check_out("R6 jump in next group unfused", 4'b0011, mk(8'h40,2,0,0),
              mk(8'h41,0,0,0), 0, 0);
    tick();
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    send(14'd0, 14'd0, sl(8'h61,1,0,0), sl(8'h60,1,1,0));
    check_out("R10 stalled lanes", 4'b0111, mk(8'h60,0,0,0), mk(8'h60,0,0,1),
              mk(8'h61,0,0,0), 0);
    tick();
    check_out("R10 lanes held", 4'b0111, mk(8'h60,0,0,0), mk(8'h60,0,0,1),
              mk(8'h61,0,0,0), 0);
    check("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    tick();
    check_out("R10 released", 4'b0000, 0, 0, 0, 0);
    check("R10 in_ready after release", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_microcode();
    mc_req_ready = 1'b0;
    send(14'd0, sl(8'h52,1,0,0), sl(8'h51,3,0,0), sl(8'h50,1,0,0));
    check_out("R8 earlier op first", 4'b0001, mk(8'h50,0,0,0), 0, 0, 0);
    check("R8 no request yet", {31'd0, mc_req_valid}, 32'd0);
    tick();
    check("R8 request raised", {31'd0, mc_req_valid}, 32'd1);
    check("R8 request tag", {24'd0, mc_req_tag}, 32'h51);
    check_out("R8 no lanes with request", 4'b0000, 0, 0, 0, 0);
    tick();
    check("R8 request held", {31'd0, mc_req_valid}, 32'd1);
    check("R8 tag held", {24'd0, mc_req_tag}, 32'h51);
    mc_req_ready = 1'b1;
    tick();
    for (int k = 0; k < 3; k++) begin
      check_out("R9 stalled while busy", 4'b0000, 0, 0, 0, 0);
      check("R9 no request while busy", {31'd0, mc_req_valid}, 32'd0);
      tick();
    end
    mc_done = 1'b1;
    tick();
    mc_done = 1'b0;
    check_out("R9 resume after done", 4'b0001, mk(8'h52,0,0,0), 0, 0, 0);
    check("R11 in_ready with last op", {31'd0, in_ready}, 32'd1);
    tick();
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_wide();
    t_two();
    t_fuse();
    t_cross();
    t_backpressure();
    t_microcode();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule